// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software through a 32-bit down-counter that runs on its own core clock. Software programs a reload value, enables counting and chooses whether the block may request a system reset. All of this goes through a small APB register file on a separate bus clock.

When the counter first runs out, the block raises an interrupt and starts counting again from the reload value. Software answers by writing the kick register. That write clears the interrupt and restarts the count. If the counter runs out a second time before the interrupt has been cleared, the block raises a reset request, provided reset generation is enabled. The reset request stays high until the core domain is reset.

Control bits pass into the core domain through two-flop synchronisers. Load and kick writes cross as toggle events. The current count comes back to the bus side through a toggle request/acknowledge snapshot.

Top module: `wdog2_top`

## Requirements
- R1: After reset the interrupt and reset-request outputs are low, control reads 0, and both the reload register and the count read 0xFFFFFFFF.
- R2: Registers are at word offsets 0x0 (reload, read/write), 0x4 (count, read-only, writes ignored), 0x8 (control: bit 0 run, bit 1 reset-enable, other bits read 0) and 0xC (kick, write any value, reads 0).
- R3: While run is set and no load or kick event occurs, the count drops by one on every core clock edge until it reaches zero.
- R4: When the count is zero while running and no interrupt is pending, the next core edge raises the interrupt and reloads the count from the reload value.
- R5: With reset-enable set, the reset request rises exactly L+1 core cycles after the interrupt rises, where L is the reload value, unless a kick arrives first.
- R6: With reset-enable clear, later expiries reload the count, the interrupt stays high and the reset request never rises.
- R7: A kick write lowers the interrupt and reloads the count. The next interrupt rises exactly L+1 core cycles after it fell. Kicks spaced closer than L+1 cycles keep the interrupt low.
- R8: Writing the reload register also reloads the count right away, and the new value reads back from the count register.
- R9: While run is clear the count holds its value and the interrupt is low.
- R10: Once high, the reset request stays high through disabling and kicks, until the core reset is applied.
- R11: A control write takes effect in the core domain within a few core cycles when both clocks come from one source. The first interrupt after enabling with reload L rises between L+1 and L+5 cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Register interface clock |
| presetn | input | 1 | Asynchronous active-low reset, bus domain |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | CNT_W | APB write data |
| prdata | output | CNT_W | APB read data |
| core_clk | input | 1 | Counter clock |
| core_rstn | input | 1 | Asynchronous active-low reset, core domain |
| irq_o | output | 1 | Interrupt after the first expiry |
| rst_req_o | output | 1 | Sticky system reset request |

## Verification
The assertions assume that the core reset is held low from time zero. They also assume that the reload register is written only while no load or kick event is in flight, so that it is stable whenever the core domain samples it. The bench drives one APB transfer at a time, with three bus cycles per transfer, and runs both clocks from one source. This keeps every reload value stable long before it is used. Random reload values are kept small enough that each escalation completes within the run.

// File: rtl/wdog2_pkg.sv
package wdog2_pkg;
  // word offsets within the register window
  localparam int unsigned OFS_LOAD  = 0;
  localparam int unsigned OFS_COUNT = 1;
  localparam int unsigned OFS_CTRL  = 2;
  localparam int unsigned OFS_KICK  = 3;

  localparam int unsigned CTRL_BITS = 2;

  typedef struct packed {
    logic rst_en;  // bit 1
    logic run;     // bit 0
  } wd_ctrl_t;
endpackage

// File: rtl/wdog2_rstsync.sv
module wdog2_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/wdog2_bitsync.sv
module wdog2_bitsync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb stg_d = {stg_q[STAGES-2:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wdog2_pulse_rx.sv
module wdog2_pulse_rx #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_i,
  output logic pulse_o
);
  logic tog_s;
  logic prev_q;

  wdog2_bitsync #(.WIDTH(1), .STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (tog_i),
    .q_o   (tog_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= tog_s;
  end

  assign pulse_o = tog_s ^ prev_q;
endmodule

// File: rtl/wdog2_regs.sv
module wdog2_regs
  import wdog2_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 4,
  parameter int unsigned       CNT_W    = 32,
  parameter logic [CNT_W-1:0]  LOAD_RST = '1
) (
  input  logic              pclk,
  input  logic              prst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CNT_W-1:0]  pwdata,
  output logic [CNT_W-1:0]  prdata,
  input  logic [CNT_W-1:0]  cnt_rd_i,
  output logic [CNT_W-1:0]  load_o,
  output wd_ctrl_t          ctrl_o,
  output logic              load_tog_o,
  output logic              kick_tog_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              wr_acc;
  logic              sel_load, sel_ctrl, sel_kick;

  logic [CNT_W-1:0]  load_q, load_d;
  wd_ctrl_t          ctrl_q, ctrl_d;
  logic              load_tog_q, load_tog_d;
  logic              kick_tog_q, kick_tog_d;

  logic unused_bits;
  assign unused_bits = ^{paddr[1:0], pwdata[CNT_W-1:CTRL_BITS]};

  assign word     = paddr[ADDR_W-1:2];
  assign wr_acc   = psel & penable & pwrite;
  assign sel_load = wr_acc && (word == WORD_W'(OFS_LOAD));
  assign sel_ctrl = wr_acc && (word == WORD_W'(OFS_CTRL));
  assign sel_kick = wr_acc && (word == WORD_W'(OFS_KICK));

  always_comb begin
    load_d     = sel_load ? pwdata : load_q;
    ctrl_d     = sel_ctrl ? wd_ctrl_t'(pwdata[CTRL_BITS-1:0]) : ctrl_q;
    load_tog_d = load_tog_q ^ sel_load;
    kick_tog_d = kick_tog_q ^ sel_kick;
  end

  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) begin
      load_q     <= LOAD_RST;
      ctrl_q     <= '0;
      load_tog_q <= 1'b0;
      kick_tog_q <= 1'b0;
    end else begin
      load_q     <= load_d;
      ctrl_q     <= ctrl_d;
      load_tog_q <= load_tog_d;
      kick_tog_q <= kick_tog_d;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (word == WORD_W'(OFS_LOAD))  prdata = load_q;
      if (word == WORD_W'(OFS_COUNT)) prdata = cnt_rd_i;
      if (word == WORD_W'(OFS_CTRL))  prdata = {{(CNT_W-CTRL_BITS){1'b0}}, ctrl_q};
    end
  end

  assign load_o     = load_q;
  assign ctrl_o     = ctrl_q;
  assign load_tog_o = load_tog_q;
  assign kick_tog_o = kick_tog_q;
endmodule

// File: rtl/wdog2_snap.sv
module wdog2_snap #(
  parameter int unsigned      CNT_W    = 32,
  parameter int unsigned      STAGES   = 2,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic             core_clk,
  input  logic             core_rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pclk,
  input  logic             prst_n,
  output logic [CNT_W-1:0] cnt_o
);
  // core side: capture when the previous snapshot has been acknowledged
  logic [CNT_W-1:0] hold_q, hold_d;
  logic             req_q, req_d;
  logic             ack_s;
  logic             idle;

  // bus side
  logic             req_s;
  logic             ack_q, ack_d;
  logic [CNT_W-1:0] rd_q, rd_d;
  logic             take;

  wdog2_bitsync #(.WIDTH(1), .STAGES(STAGES)) u_ack_sync (
    .clk (core_clk), .rst_n (core_rst_n), .d_i (ack_q), .q_o (ack_s)
  );

  wdog2_bitsync #(.WIDTH(1), .STAGES(STAGES)) u_req_sync (
    .clk (pclk), .rst_n (prst_n), .d_i (req_q), .q_o (req_s)
  );

  assign idle = (ack_s == req_q);

  always_comb begin
    hold_d = idle ? cnt_i : hold_q;
    req_d  = idle ? ~req_q : req_q;
  end

  always_ff @(posedge core_clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      hold_q <= LOAD_RST;
      req_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      req_q  <= req_d;
    end
  end

  assign take = (req_s != ack_q);

  always_comb begin
    rd_d  = take ? hold_q : rd_q;
    ack_d = take ? req_s  : ack_q;
  end

  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) begin
      rd_q  <= LOAD_RST;
      ack_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      ack_q <= ack_d;
    end
  end

  assign cnt_o = rd_q;
endmodule

// File: rtl/wdog2_core.sv
module wdog2_core #(
  parameter int unsigned      CNT_W    = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             rst_en_i,
  input  logic             load_evt_i,
  input  logic             kick_evt_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             rst_q, rst_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    irq_d = irq_q;
    rst_d = rst_q;
    if (load_evt_i || kick_evt_i) begin
      cnt_d = load_val_i;
    end else if (run_i) begin
      if (at_zero) begin
        cnt_d = load_val_i;
        if (!irq_q)        irq_d = 1'b1;
        else if (rst_en_i) rst_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (kick_evt_i || !run_i) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LOAD_RST;
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
      rst_q <= rst_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/wdog2_top.sv
module wdog2_top
  import wdog2_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 4,
  parameter int unsigned      CNT_W    = 32,
  parameter int unsigned      SYNC_N   = 2,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CNT_W-1:0]  pwdata,
  output logic [CNT_W-1:0]  prdata,
  input  logic              core_clk,
  input  logic              core_rstn,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic             prst_n, crst_n;
  logic [CNT_W-1:0] load_val, cnt_rd, core_cnt;
  wd_ctrl_t         ctrl;
  logic             load_tog, kick_tog;
  logic             run_s, rst_en_s;
  logic             load_evt, kick_evt;

  wdog2_rstsync #(.STAGES(SYNC_N)) u_prst (
    .clk (pclk), .arst_n (presetn), .rst_n_o (prst_n)
  );
  wdog2_rstsync #(.STAGES(SYNC_N)) u_crst (
    .clk (core_clk), .arst_n (core_rstn), .rst_n_o (crst_n)
  );

  wdog2_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_regs (
    .pclk       (pclk),
    .prst_n     (prst_n),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .pwdata     (pwdata),
    .prdata     (prdata),
    .cnt_rd_i   (cnt_rd),
    .load_o     (load_val),
    .ctrl_o     (ctrl),
    .load_tog_o (load_tog),
    .kick_tog_o (kick_tog)
  );

  wdog2_bitsync #(.WIDTH(CTRL_BITS), .STAGES(SYNC_N)) u_ctrl_sync (
    .clk   (core_clk),
    .rst_n (crst_n),
    .d_i   ({ctrl.rst_en, ctrl.run}),
    .q_o   ({rst_en_s, run_s})
  );

  wdog2_pulse_rx #(.STAGES(SYNC_N)) u_load_rx (
    .clk (core_clk), .rst_n (crst_n), .tog_i (load_tog), .pulse_o (load_evt)
  );
  wdog2_pulse_rx #(.STAGES(SYNC_N)) u_kick_rx (
    .clk (core_clk), .rst_n (crst_n), .tog_i (kick_tog), .pulse_o (kick_evt)
  );

  wdog2_core #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_core (
    .clk        (core_clk),
    .rst_n      (crst_n),
    .run_i      (run_s),
    .rst_en_i   (rst_en_s),
    .load_evt_i (load_evt),
    .kick_evt_i (kick_evt),
    .load_val_i (load_val),
    .cnt_o      (core_cnt),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o)
  );

  wdog2_snap #(.CNT_W(CNT_W), .STAGES(SYNC_N), .LOAD_RST(LOAD_RST)) u_snap (
    .core_clk   (core_clk),
    .core_rst_n (crst_n),
    .cnt_i      (core_cnt),
    .pclk       (pclk),
    .prst_n     (prst_n),
    .cnt_o      (cnt_rd)
  );
endmodule

// File: rtl/wdog2_chk.sv
module wdog2_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             core_clk,
  input logic             core_rstn,
  input logic             irq,
  input logic             rst_req,
  input logic             run_s,
  input logic             rst_en_s,
  input logic             load_evt,
  input logic             kick_evt,
  input logic [CNT_W-1:0] cnt
);
  assert_rst_sticky_R10: assert property (@(posedge core_clk) disable iff (!core_rstn)
    rst_req |=> rst_req);

  assert_rst_gated_R6: assert property (@(posedge core_clk) disable iff (!core_rstn)
    $rose(rst_req) |-> ($past(rst_en_s) && $past(irq)));

  assert_irq_at_zero_R4: assert property (@(posedge core_clk) disable iff (!core_rstn)
    $rose(irq) |-> ($past(cnt) == '0));

  assert_hold_when_off_R9: assert property (@(posedge core_clk) disable iff (!core_rstn)
    (!run_s && !load_evt && !kick_evt) |=> ($stable(cnt) && !irq));

  assert_kick_clears_R7: assert property (@(posedge core_clk) disable iff (!core_rstn)
    kick_evt |=> !irq);

  assert_step_down_R3: assert property (@(posedge core_clk) disable iff (!core_rstn)
    (run_s && !load_evt && !kick_evt && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));
endmodule

bind wdog2_top wdog2_chk #(.CNT_W(CNT_W)) u_chk (
  .core_clk  (core_clk),
  .core_rstn (core_rstn),
  .irq       (irq_o),
  .rst_req   (rst_req_o),
  .run_s     (run_s),
  .rst_en_s  (rst_en_s),
  .load_evt  (load_evt),
  .kick_evt  (kick_evt),
  .cnt       (core_cnt)
);

// File: tb/wdog2_top_tb.sv
module wdog2_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_LOAD = 4'h0, A_CNT = 4'h4, A_CTRL = 4'h8, A_KICK = 4'hC;

  logic clk = 1'b0;
  logic presetn, core_rstn;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic irq_o, rst_req_o;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog2_top u_dut (
    .pclk (clk), .presetn (presetn), .psel (psel), .penable (penable),
    .pwrite (pwrite), .paddr (paddr), .pwdata (pwdata), .prdata (prdata),
    .core_clk (clk), .core_rstn (core_rstn), .irq_o (irq_o), .rst_req_o (rst_req_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic apb_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); presetn = 0; core_rstn = 0;
    repeat (3) @(negedge clk);
    presetn = 1; core_rstn = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_sig(input bit want_rst, input logic lvl, input int maxc,
                          output int t, output bit ok);
    ok = 0; t = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if ((want_rst ? rst_req_o : irq_o) == lvl) begin t = cyc; ok = 1; return; end
    end
  endtask

  // expected first-irq window after the enabling write (R11)
  function automatic bit in_window(input int dt, input int l);
    return (dt >= l + 1) && (dt <= l + 5);
  endfunction

  task automatic escalate(input int l, input bit rsten);
    int t0, t1, t2, bad; bit ok;
    do_reset();
    apb_wr(A_LOAD, 32'(l));
    apb_wr(A_CTRL, rsten ? 32'h3 : 32'h1);
    t0 = cyc;
    wait_sig(0, 1'b1, l + 20, t1, ok);
    check(ok, "R4", "first expiry raises irq", ok, 1);
    check(in_window(t1 - t0, l), "R11", "write-to-irq latency", t1 - t0, l + 3);
    if (rsten) begin
      wait_sig(1, 1'b1, l + 20, t2, ok);
      check(ok && (t2 - t1 == l + 1), "R5", "irq-to-reset interval", t2 - t1, l + 1);
    end else begin
      bad = 0;
      repeat (3 * (l + 1) + 4) begin
        @(negedge clk);
        if (rst_req_o || !irq_o) bad++;
      end
      check(bad == 0, "R6", "no reset with reset-enable clear", bad, 0);
    end
  endtask

  task automatic kick_interval(input int l);
    int t1, t2, tx; bit ok;
    do_reset();
    apb_wr(A_LOAD, 32'(l));
    apb_wr(A_CTRL, 32'h3);
    wait_sig(0, 1'b1, l + 20, tx, ok);
    apb_wr(A_KICK, 32'hDEAD_BEEF);
    wait_sig(0, 1'b0, 10, t1, ok);
    check(ok, "R7", "kick lowers irq", ok, 1);
    wait_sig(0, 1'b1, l + 20, t2, ok);
    check(ok && (t2 - t1 == l + 1), "R7", "kick-to-next-irq interval", t2 - t1, l + 1);
    check(rst_req_o == 1'b0, "R5", "no reset after timely kick", rst_req_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] d, c1, c2, v;
    int bad, seed_sink;
    presetn = 0; core_rstn = 0;
    seed_sink = $urandom(32'h5EED_0042);
    do_reset();

    // R1 reset state
    check(irq_o == 0 && rst_req_o == 0, "R1", "outputs low after reset", {irq_o, rst_req_o}, 0);
    apb_rd(A_CTRL, d); check(d == 0, "R1", "ctrl after reset", d, 0);
    apb_rd(A_LOAD, d); check(d == 32'hFFFF_FFFF, "R1", "reload after reset", d, 32'hFFFF_FFFF);
    apb_rd(A_CNT, d);  check(d == 32'hFFFF_FFFF, "R1", "count after reset", d, 32'hFFFF_FFFF);

    // R2 register map, R8 load reloads
    v = $urandom; apb_wr(A_LOAD, v); repeat (30) @(negedge clk);
    apb_rd(A_LOAD, d); check(d == v, "R2", "reload readback", d, v);
    apb_rd(A_CNT, d);  check(d == v, "R8", "count takes reload", d, v);
    apb_wr(A_CNT, ~v); repeat (30) @(negedge clk);
    apb_rd(A_CNT, d);  check(d == v, "R2", "count write ignored", d, v);
    apb_rd(A_KICK, d); check(d == 0, "R2", "kick reads zero", d, 0);
    apb_wr(A_CTRL, 32'hFFFF_FFFC); apb_rd(A_CTRL, d);
    check(d == 0, "R2", "ctrl upper bits ignored", d, 0);
    apb_wr(A_CTRL, 32'h1); apb_rd(A_CTRL, d);
    check(d == 1, "R2", "ctrl run bit", d, 1);

    // R3 counts down, R9 holds when off
    apb_wr(A_LOAD, 32'd5000); repeat (20) @(negedge clk);
    apb_rd(A_CNT, c1); repeat (50) @(negedge clk); apb_rd(A_CNT, c2);
    check(c2 < c1 && c1 < 5000, "R3", "count decreasing while running", c1 - c2, 53);
    apb_wr(A_CTRL, 32'h0); repeat (30) @(negedge clk);
    apb_rd(A_CNT, c1); repeat (100) @(negedge clk); apb_rd(A_CNT, c2);
    check(c1 == c2, "R9", "count held while off", c2, c1);
    check(irq_o == 0, "R9", "irq low while off", irq_o, 0);

    // R5/R6 random escalation trials
    for (int k = 0; k < 6; k++) escalate(3 + int'($urandom % 40), bit'($urandom % 2));
    escalate(12, 1'b1);
    escalate(9, 1'b0);
    // R9: disabling drops a pending irq
    apb_wr(A_CTRL, 32'h0); repeat (10) @(negedge clk);
    check(irq_o == 0, "R9", "disable clears irq", irq_o, 0);

    // R10 sticky reset
    escalate(6, 1'b1);
    apb_wr(A_CTRL, 32'h0); apb_wr(A_KICK, 32'h1); repeat (20) @(negedge clk);
    check(rst_req_o == 1, "R10", "reset stays high", rst_req_o, 1);
    do_reset();
    check(rst_req_o == 0, "R10", "core reset clears request", rst_req_o, 0);

    // R7 kick intervals and periodic kicks
    for (int k = 0; k < 3; k++) kick_interval(8 + int'($urandom % 30));
    do_reset();
    apb_wr(A_LOAD, 32'd30); apb_wr(A_CTRL, 32'h3);
    bad = 0;
    repeat (30) begin
      apb_wr(A_KICK, $urandom);
      repeat (7) begin @(negedge clk); if (irq_o || rst_req_o) bad++; end
    end
    check(bad == 0, "R7", "periodic kicks keep irq low", bad, 0);

    finish_run();
  end
endmodule